// File: doc/BRIEF.md
# PWM Output Action Qualifier

This block sits between a PWM time-base counter and two output pins, A and B. On every counter tick it looks at which counter events are present (count reached zero, count reached the period value, count matched compare A, count matched compare B, together with the count direction). It then sets, clears, toggles or holds each output, following a per-output table of 2-bit actions.

Software can step in at two levels. A one-shot force applies a single action to an output on the next tick and then disarms itself. A continuous force holds an output low or high for as long as it is in force. The continuous-force value is written to a shadow copy. That copy reaches the active setting at a selectable point: at counter zero, at period, at either of these, or at once. With the immediate option software can stop an output cleanly at the very next tick.

Registers are written through a simple select/data port. The outputs are registered and change only on clock edges where the tick input is high.

Top module: `pwm_action_qual`

## Requirements
- R1: While rst_n is low, both outputs are 0. Reset clears every action word, the one-shot settings and both force settings (shadow and active), and sets the reload select to 00.
- R2: The outputs change only at a clock edge where tick is 1. Event inputs present without tick have no effect.
- R3: wr_sel 00 writes the action word of output A and wr_sel 01 the word of output B. Each word holds 2-bit fields: [1:0] zero, [3:2] period, [5:4] compare A counting up, [7:6] compare A counting down, [9:8] compare B counting up, [11:10] compare B counting down. Codes: 00 hold, 01 drive 0, 10 drive 1, 11 invert.
- R4: cnt_up=1 selects the counting-up compare fields and cnt_up=0 selects the counting-down fields.
- R5: When several events share a tick, only the highest present one decides, even if its code is 00. The order, highest first, is: one-shot, compare A, compare B, period, zero.
- R6: wr_sel 10 writes the one-shot register: A action [1:0] and arm bit [2], B action [4:3] and arm bit [5], using the R3 codes. An armed one-shot acts on the next tick and is then disarmed, so it acts once.
- R7: wr_sel 11 writes the continuous-force shadow: A in [1:0], B in [3:2]. An active code of 01 holds the output at 0 and 10 holds it at 1, overriding events and the one-shot. Codes 00 and 11 release the output to normal action.
- R8: Bits [7:6] of the wr_sel 10 write choose when the shadow becomes active: 00 on a tick with zero, 01 on a tick with period, 10 on a tick with zero or period, 11 at once. A value loaded on a tick already governs that tick.
- R9: With reload select 11, a continuous force written in one cycle governs the next tick after the write, whatever the events on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter tick; events are evaluated only when high |
| cnt_zero | input | 1 | Counter equals zero |
| cnt_period | input | 1 | Counter equals period |
| cnt_up | input | 1 | Count direction, 1 = up |
| cmp_a_hit | input | 1 | Counter equals compare A |
| cmp_b_hit | input | 1 | Counter equals compare B |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select |
| wr_data | input | DW | Register write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
Every piece of internal state shows up at the outputs no later than the first tick that consults it. A wrong action field or priority decision gives a wrong level right after that tick. A one-shot that fails to disarm inverts or drives the line again on the following event-free tick. A shadow force loaded at the wrong reload point shows as a line that follows events when it should be held, or the reverse. The bench therefore ticks repeatedly around each reload point and right after each one-shot, and it samples both lines after every tick.

// File: rtl/pwm_action_qual.sv
module pwm_action_qual #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_zero,
  input  logic          cnt_period,
  input  logic          cnt_up,
  input  logic          cmp_a_hit,
  input  logic          cmp_b_hit,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic          pwm_a,
  output logic          pwm_b
);
  localparam int AWW = 12;

  logic [AWW-1:0] word_a, word_b;
  logic [1:0] os_act_a, os_act_b;
  logic       os_arm_a, os_arm_b;
  logic [1:0] rld;
  logic [1:0] sh_a, sh_b, hold_a, hold_b;
  logic [1:0] eff_a, eff_b;
  logic       load_now, nxt_a, nxt_b;

  wire wr_word_a = wr_en && wr_sel == 2'd0;
  wire wr_word_b = wr_en && wr_sel == 2'd1;
  wire wr_os     = wr_en && wr_sel == 2'd2;
  wire wr_frc    = wr_en && wr_sel == 2'd3;

  assign load_now = tick && ((rld == 2'd0 && cnt_zero) ||
                             (rld == 2'd1 && cnt_period) ||
                             (rld == 2'd2 && (cnt_zero || cnt_period)));
  assign eff_a = load_now ? sh_a : hold_a;
  assign eff_b = load_now ? sh_b : hold_b;

  function automatic logic [1:0] pick(input logic [AWW-1:0] w, input logic arm,
                                      input logic [1:0] os, input logic up,
                                      input logic ca, input logic cb,
                                      input logic prd, input logic zro);
    if (arm)      return os;
    else if (ca)  return up ? w[5:4] : w[7:6];
    else if (cb)  return up ? w[9:8] : w[11:10];
    else if (prd) return w[3:2];
    else if (zro) return w[1:0];
    else          return 2'b00;
  endfunction

  function automatic logic apply(input logic [1:0] frc, input logic [1:0] act,
                                 input logic cur);
    if (frc == 2'b01) return 1'b0;
    if (frc == 2'b10) return 1'b1;
    case (act)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  assign nxt_a = apply(eff_a, pick(word_a, os_arm_a, os_act_a, cnt_up,
                       cmp_a_hit, cmp_b_hit, cnt_period, cnt_zero), pwm_a);
  assign nxt_b = apply(eff_b, pick(word_b, os_arm_b, os_act_b, cnt_up,
                       cmp_a_hit, cmp_b_hit, cnt_period, cnt_zero), pwm_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_a <= '0; word_b <= '0;
      os_act_a <= '0; os_act_b <= '0;
      os_arm_a <= 1'b0; os_arm_b <= 1'b0;
      rld <= '0;
      sh_a <= '0; sh_b <= '0; hold_a <= '0; hold_b <= '0;
      pwm_a <= 1'b0; pwm_b <= 1'b0;
    end else begin
      if (wr_word_a) word_a <= wr_data[AWW-1:0];
      if (wr_word_b) word_b <= wr_data[AWW-1:0];
      if (tick) begin
        os_arm_a <= 1'b0;
        os_arm_b <= 1'b0;
        pwm_a    <= nxt_a;
        pwm_b    <= nxt_b;
      end
      if (wr_os) begin
        os_act_a <= wr_data[1:0];
        os_act_b <= wr_data[4:3];
        rld      <= wr_data[7:6];
        if (wr_data[2]) os_arm_a <= 1'b1;
        if (wr_data[5]) os_arm_b <= 1'b1;
      end
      if (wr_frc) begin
        sh_a <= wr_data[1:0];
        sh_b <= wr_data[3:2];
      end
      if (rld == 2'd3) begin
        hold_a <= wr_frc ? wr_data[1:0] : sh_a;
        hold_b <= wr_frc ? wr_data[3:2] : sh_b;
      end else if (load_now) begin
        hold_a <= sh_a;
        hold_b <= sh_b;
      end
    end
  end

  // R1
  rst_low_chk: assert property (@(posedge clk) !rst_n |=> !pwm_a && !pwm_b);

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_a) && $stable(pwm_b));

  // R6
  os_disarm_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !(wr_os && wr_data[2]) |=> !os_arm_a);

  // R6
  os_disarm_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !(wr_os && wr_data[5]) |=> !os_arm_b);

  // R7
  frc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && eff_a == 2'b01 |=> !pwm_a);

  // R7
  frc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && eff_b == 2'b10 |=> pwm_b);

  // R9
  imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rld == 2'd3 && wr_frc |=> hold_a == $past(wr_data[1:0]) &&
                              hold_b == $past(wr_data[3:2]));
endmodule

// File: tb/pwm_action_qual_test.sv
module pwm_action_qual_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cnt_zero = 0, cnt_period = 0, cnt_up = 1, cmp_a_hit = 0, cmp_b_hit = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic pwm_a, pwm_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_action_qual #(.DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_zero(cnt_zero),
    .cnt_period(cnt_period), .cnt_up(cnt_up), .cmp_a_hit(cmp_a_hit),
    .cmp_b_hit(cmp_b_hit), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b));

  // {zero, period, up, cmpA, cmpB, expA, expB}
  localparam logic [6:0] VEC [13] = '{
    7'b1010010, 7'b0011000, 7'b0010101, 7'b0110011, 7'b0001011,
    7'b0000100, 7'b1010010, 7'b1011000, 7'b0110101, 7'b0100110,
    7'b1110001, 7'b0011101, 7'b0010001};

  task automatic check(input logic ea, input logic eb, input string req);
    checks++;
    if (pwm_a !== ea || pwm_b !== eb) begin
      errors++;
      $display("FAIL %s: got a=%0b b=%0b expected a=%0b b=%0b", req, pwm_a, pwm_b, ea, eb);
    end
  endtask

  task automatic step(input logic t, input logic z, input logic p, input logic u,
                      input logic ca, input logic cb);
    @(negedge clk);
    tick = t; cnt_zero = z; cnt_period = p; cnt_up = u; cmp_a_hit = ca; cmp_b_hit = cb;
    @(negedge clk);
    tick = 0; cnt_zero = 0; cnt_period = 0; cmp_a_hit = 0; cmp_b_hit = 0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(0, 0, "R1 reset");
    rst_n = 1;
    // R3 words: A zero=hi per=tgl CAU=lo CAD=hi CBU=hold CBD=tgl; B zero=lo per=hi CBU=tgl CBD=lo
    wr(2'd0, 16'h0C9E);
    wr(2'd1, 16'h0709);
    for (int i = 0; i < 13; i++) begin
      step(1, VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      check(VEC[i][1], VEC[i][0], $sformatf("R3 R4 R5 vector %0d", i));
    end
    // R2: events without tick ignored
    step(0, 1, 1, 1, 1, 1);
    check(0, 1, "R2 no tick");
    // R6 one-shot A invert beats compare A (would drive 0)
    wr(2'd2, 16'h0007);
    step(1, 0, 0, 1, 1, 0);
    check(1, 1, "R6 one-shot A");
    step(1, 0, 0, 1, 0, 0);
    check(1, 1, "R6 one-shot disarmed");
    // R6 one-shot B clear beats period
    wr(2'd2, 16'h0028);
    step(1, 0, 1, 1, 0, 0);
    check(0, 0, "R6 one-shot B");
    // R8 reload at zero, force both low
    wr(2'd3, 16'h0005);
    step(1, 0, 1, 1, 0, 0);
    check(1, 1, "R8 not loaded at period");
    step(1, 1, 0, 1, 0, 0);
    check(0, 0, "R8 loaded at zero");
    step(1, 0, 1, 1, 0, 0);
    check(0, 0, "R7 force low holds");
    // R7 force overrides one-shot set
    wr(2'd2, 16'h0006);
    step(1, 0, 0, 1, 0, 0);
    check(0, 0, "R7 force beats one-shot");
    // R7 code 11 releases, loaded at zero
    wr(2'd3, 16'h000F);
    step(1, 0, 1, 1, 0, 0);
    check(0, 0, "R8 release waits for zero");
    step(1, 1, 0, 1, 0, 0);
    check(1, 0, "R7 released");
    // R8 reload at period, force high
    wr(2'd2, 16'h0040);
    wr(2'd3, 16'h000A);
    step(1, 1, 0, 1, 0, 0);
    check(1, 0, "R8 period mode ignores zero");
    step(1, 0, 1, 1, 0, 0);
    check(1, 1, "R8 loaded at period");
    // R8 zero-or-period
    wr(2'd2, 16'h0080);
    wr(2'd3, 16'h0005);
    step(1, 1, 0, 1, 0, 0);
    check(0, 0, "R8 either mode at zero");
    wr(2'd3, 16'h000F);
    step(1, 0, 1, 1, 0, 0);
    check(1, 1, "R8 either mode at period");
    // R9 immediate stop
    wr(2'd2, 16'h00C0);
    wr(2'd3, 16'h0005);
    check(1, 1, "R9 no change before tick");
    step(1, 1, 0, 1, 0, 0);
    check(0, 0, "R9 immediate force low");
    // R1 reset mid-run clears words
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    check(0, 0, "R1 mid-run reset");
    step(1, 1, 1, 1, 1, 1);
    check(0, 0, "R1 words cleared");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule